// File: doc/BRIEF.md
# Interleaved Burst Packet Tracker

This block sits on a receive user interface that delivers packets from up to 256 logical channels. The link splits each packet into bursts, and bursts of different channels may arrive interleaved. Each cycle carries one beat of four 64-bit words. Valid words are packed toward the most significant word, so the first word is at the top. Each beat also carries burst and packet markers, a valid-word count, an end-of-packet field and a channel number. The channel number is reliable only on the first beat of a burst.

The tracker registers the channel at the start of every burst and applies it to every later beat of that burst. For every channel it keeps an in-packet flag and a running byte count, so a packet can resume after bursts of other channels. It tags each accepted beat with its channel. When a packet ends it emits a one-cycle completion carrying the channel and the total byte length. It pulses one of four error outputs when the markers break the protocol. All outputs are registered and appear one cycle after the beat that caused them.

Top module: `ilv_burst_tracker`

## Requirements
- R1: A non-idle beat that starts a burst, or that arrives while a burst is open, appears one cycle later with beat_valid high. Its data and valid-word count are unchanged and it is tagged with its channel.
- R2: The channel is taken from in_chan on start-of-burst beats. The other beats of that burst carry the registered channel, whatever in_chan shows.
- R3: A beat with in_nvalid equal to 0 is idle. It produces no output, no completion and no error, and it changes no burst or packet state, whatever the other inputs show.
- R4: Per-channel packet state is kept while bursts of other channels are interleaved. A packet's length is the sum of the bytes of all its beats.
- R5: A beat with in_eop[3] clear contributes in_nvalid*8 bytes. A beat with in_eop[3] set contributes (in_nvalid-1)*8 bytes plus in_eop[2:0] bytes, where in_eop[2:0]=0 means 8 bytes. In_nvalid values 5 to 7 count as 4.
- R6: A beat with in_eop[3] set produces a one-cycle done_valid, one cycle later, carrying that channel and the packet's total length. The channel's state is then cleared.
- R7: Start-of-packet on a start-of-burst beat, for a channel already in a packet, pulses err_sop_dup. The count then restarts from that beat.
- R8: A start-of-burst beat without start-of-packet, for a channel not in a packet, pulses err_orphan. The packet is then opened and counts from that beat.
- R9: A non-idle beat without start-of-burst while no burst is open pulses err_stray. The beat is dropped, with no tagged beat and no state change.
- R10: A start-of-burst beat while a burst is open pulses err_reopen. The new burst and its channel replace the open one.
- R11: Start-of-packet on a beat without start-of-burst is ignored.
- R12: A synchronous active-high reset clears all channel state, the open-burst flag and all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_sob | input | 1 | Start of burst |
| in_eob | input | 1 | End of burst |
| in_sop | input | 1 | Start of packet, meaningful with in_sob |
| in_nvalid | input | 3 | Number of valid words, 0 = idle |
| in_eop | input | 4 | Bit 3 = packet ends here; bits 2:0 = bytes in last word (0 = 8) |
| in_chan | input | 8 | Channel, valid on start-of-burst beats |
| in_data | input | 256 | Four 64-bit words, first word at the top |
| beat_valid | output | 1 | Tagged beat present |
| beat_chan | output | 8 | Resolved channel of the beat |
| beat_nvalid | output | 3 | Valid-word count of the beat |
| beat_data | output | 256 | Beat data |
| done_valid | output | 1 | Packet completion pulse |
| done_chan | output | 8 | Channel of the finished packet |
| done_len | output | 16 | Byte length of the finished packet |
| err_sop_dup | output | 1 | Start of packet on a channel already in a packet |
| err_orphan | output | 1 | Continuation burst on a channel not in a packet |
| err_stray | output | 1 | Non-idle beat outside any burst |
| err_reopen | output | 1 | Start of burst while a burst is open |

## Verification
A completion and a protocol error can fall in the same cycle. The bench provokes this in two ways. It sends a one-beat packet with start-of-packet on a channel still holding an open packet. It also starts and ends a packet on a new channel while another burst is left open. In both cases it expects the error pulse together with done_valid, and a length that counts only the restarted or new packet. A follow-up packet on the displaced channel then checks that its saved count was untouched.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    // One flag per protocol violation, pulsed for a single cycle.
    typedef struct packed {
        logic sop_dup;
        logic orphan;
        logic stray;
        logic reopen;
    } ilv_err_t;

endpackage

// File: rtl/ilv_beat_bytes.sv
// Byte contribution of one beat, from its word count and end-of-packet field.
module ilv_beat_bytes #(
    parameter int NUM_WORDS  = 4,
    parameter int WORD_BYTES = 8,
    parameter int NV_W       = 3,
    parameter int LB_W       = 3,
    parameter int BB_W       = 6
) (
    input  logic [NV_W-1:0] nvalid,
    input  logic            last_beat,
    input  logic [LB_W-1:0] last_bytes,
    output logic [BB_W-1:0] bytes
);
    int words;
    int tail;
    int total;

    always_comb begin
        words = int'(nvalid);
        if (words > NUM_WORDS) begin
            words = NUM_WORDS;
        end
        tail = (last_bytes == '0) ? WORD_BYTES : int'(last_bytes);
        if (last_beat && words != 0) begin
            total = (words - 1) * WORD_BYTES + tail;
        end else begin
            total = words * WORD_BYTES;
        end
        bytes = BB_W'(total);
    end
endmodule

// File: rtl/ilv_chan_table.sv
// Per-channel in-packet flag and running byte count, one entry per channel.
module ilv_chan_table #(
    parameter int CHAN_W = 8,
    parameter int LEN_W  = 16,
    localparam int NCH   = 1 << CHAN_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CHAN_W-1:0] rd_chan,
    output logic              rd_in_pkt,
    output logic [LEN_W-1:0]  rd_count,
    input  logic              wr_en,
    input  logic [CHAN_W-1:0] wr_chan,
    input  logic              wr_in_pkt,
    input  logic [LEN_W-1:0]  wr_count
);
    logic              pkt_arr [NCH];
    logic [LEN_W-1:0]  cnt_arr [NCH];

    for (genvar i = 0; i < NCH; i++) begin : g_entry
        logic             pkt_q;
        logic [LEN_W-1:0] cnt_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                pkt_q <= 1'b0;
                cnt_q <= '0;
            end else if (wr_en && wr_chan == CHAN_W'(i)) begin
                pkt_q <= wr_in_pkt;
                cnt_q <= wr_count;
            end
        end

        assign pkt_arr[i] = pkt_q;
        assign cnt_arr[i] = cnt_q;
    end

    assign rd_in_pkt = pkt_arr[rd_chan];
    assign rd_count  = cnt_arr[rd_chan];
endmodule

// File: rtl/ilv_burst_tracker.sv
module ilv_burst_tracker #(
    parameter int NUM_WORDS  = 4,
    parameter int WORD_BYTES = 8,
    parameter int CHAN_W     = 8,
    parameter int LEN_W      = 16,
    localparam int DATA_W    = NUM_WORDS * WORD_BYTES * 8,
    localparam int NV_W      = $clog2(NUM_WORDS + 1),
    localparam int LB_W      = $clog2(WORD_BYTES),
    localparam int EOP_W     = LB_W + 1,
    localparam int BB_W      = $clog2(NUM_WORDS * WORD_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_sob,
    input  logic              in_eob,
    input  logic              in_sop,
    input  logic [NV_W-1:0]   in_nvalid,
    input  logic [EOP_W-1:0]  in_eop,
    input  logic [CHAN_W-1:0] in_chan,
    input  logic [DATA_W-1:0] in_data,
    output logic              beat_valid,
    output logic [CHAN_W-1:0] beat_chan,
    output logic [NV_W-1:0]   beat_nvalid,
    output logic [DATA_W-1:0] beat_data,
    output logic              done_valid,
    output logic [CHAN_W-1:0] done_chan,
    output logic [LEN_W-1:0]  done_len,
    output logic              err_sop_dup,
    output logic              err_orphan,
    output logic              err_stray,
    output logic              err_reopen
);
    import ilv_pkg::*;

    typedef struct packed {
        logic              open;
        logic [CHAN_W-1:0] chan;
        logic              bv;
        logic [CHAN_W-1:0] bchan;
        logic [NV_W-1:0]   bnv;
        logic [DATA_W-1:0] bdata;
        logic              dv;
        logic [CHAN_W-1:0] dchan;
        logic [LEN_W-1:0]  dlen;
        ilv_err_t          err;
    } trk_state_t;

    trk_state_t s_d, s_q;

    logic              active;
    logic              accept;
    logic [CHAN_W-1:0] chan_eff;
    logic              rd_in_pkt;
    logic [LEN_W-1:0]  rd_count;
    logic              wr_en;
    logic              wr_in_pkt;
    logic [LEN_W-1:0]  wr_count;
    logic [BB_W-1:0]   beat_bytes;
    logic [LEN_W-1:0]  base_len;
    logic [LEN_W-1:0]  total_len;
    logic              burst_open;

    assign active   = in_nvalid != '0;
    assign accept   = active && (in_sob || s_q.open);
    assign chan_eff = in_sob ? in_chan : s_q.chan;

    ilv_beat_bytes #(
        .NUM_WORDS (NUM_WORDS),
        .WORD_BYTES(WORD_BYTES),
        .NV_W      (NV_W),
        .LB_W      (LB_W),
        .BB_W      (BB_W)
    ) u_bytes (
        .nvalid    (in_nvalid),
        .last_beat (in_eop[EOP_W-1]),
        .last_bytes(in_eop[LB_W-1:0]),
        .bytes     (beat_bytes)
    );

    ilv_chan_table #(
        .CHAN_W(CHAN_W),
        .LEN_W (LEN_W)
    ) u_table (
        .clk      (clk),
        .rst      (rst),
        .rd_chan  (chan_eff),
        .rd_in_pkt(rd_in_pkt),
        .rd_count (rd_count),
        .wr_en    (wr_en),
        .wr_chan  (chan_eff),
        .wr_in_pkt(wr_in_pkt),
        .wr_count (wr_count)
    );

    always_comb begin
        s_d        = s_q;
        s_d.bv     = 1'b0;
        s_d.dv     = 1'b0;
        s_d.err    = '0;
        wr_en      = 1'b0;
        wr_in_pkt  = 1'b0;
        wr_count   = '0;
        base_len   = (in_sob && in_sop) ? '0 : rd_count;
        total_len  = base_len + LEN_W'(beat_bytes);

        if (active) begin
            if (in_sob) begin
                s_d.err.reopen = s_q.open;
                s_d.chan       = in_chan;
                if (in_sop) begin
                    s_d.err.sop_dup = rd_in_pkt;
                end else begin
                    s_d.err.orphan  = !rd_in_pkt;
                end
            end else if (!s_q.open) begin
                s_d.err.stray = 1'b1;
            end
        end

        if (accept) begin
            s_d.bv    = 1'b1;
            s_d.bchan = chan_eff;
            s_d.bnv   = in_nvalid;
            s_d.bdata = in_data;
            s_d.open  = !in_eob;
            wr_en     = 1'b1;
            if (in_eop[EOP_W-1]) begin
                s_d.dv    = 1'b1;
                s_d.dchan = chan_eff;
                s_d.dlen  = total_len;
            end else begin
                wr_in_pkt = 1'b1;
                wr_count  = total_len;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign burst_open  = s_q.open;
    assign beat_valid  = s_q.bv;
    assign beat_chan   = s_q.bchan;
    assign beat_nvalid = s_q.bnv;
    assign beat_data   = s_q.bdata;
    assign done_valid  = s_q.dv;
    assign done_chan   = s_q.dchan;
    assign done_len    = s_q.dlen;
    assign err_sop_dup = s_q.err.sop_dup;
    assign err_orphan  = s_q.err.orphan;
    assign err_stray   = s_q.err.stray;
    assign err_reopen  = s_q.err.reopen;
endmodule

// File: rtl/ilv_burst_tracker_chk.sv
module ilv_burst_tracker_chk #(
    parameter int CHAN_W = 8,
    parameter int NV_W   = 3,
    parameter int LEN_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              in_sob,
    input logic [NV_W-1:0]   in_nvalid,
    input logic [CHAN_W-1:0] in_chan,
    input logic              burst_open,
    input logic              beat_valid,
    input logic [CHAN_W-1:0] beat_chan,
    input logic              done_valid,
    input logic [LEN_W-1:0]  done_len,
    input logic              err_sop_dup,
    input logic              err_orphan,
    input logic              err_stray,
    input logic              err_reopen
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (in_nvalid == '0) |=> (!beat_valid && !done_valid && !err_sop_dup && !err_orphan && !err_stray && !err_reopen)); // R3

    AST_SOB_CHAN: assert property (@(posedge clk) disable iff (rst)
        (in_nvalid != '0 && in_sob) |=> (beat_valid && beat_chan == $past(in_chan))); // R2

    AST_STRAY_DROP: assert property (@(posedge clk) disable iff (rst)
        (in_nvalid != '0 && !in_sob && !burst_open) |=> (err_stray && !beat_valid && !done_valid)); // R9

    AST_REOPEN_FLAG: assert property (@(posedge clk) disable iff (rst)
        (in_nvalid != '0 && in_sob && burst_open) |=> err_reopen); // R10

    AST_DONE_WITH_BEAT: assert property (@(posedge clk) disable iff (rst)
        done_valid |-> (beat_valid && done_len != '0)); // R6
endmodule

bind ilv_burst_tracker ilv_burst_tracker_chk #(
    .CHAN_W(CHAN_W),
    .NV_W  (NV_W),
    .LEN_W (LEN_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_sob     (in_sob),
    .in_nvalid  (in_nvalid),
    .in_chan    (in_chan),
    .burst_open (burst_open),
    .beat_valid (beat_valid),
    .beat_chan  (beat_chan),
    .done_valid (done_valid),
    .done_len   (done_len),
    .err_sop_dup(err_sop_dup),
    .err_orphan (err_orphan),
    .err_stray  (err_stray),
    .err_reopen (err_reopen)
);

// File: tb/tb_ilv_burst_tracker.sv
module tb_ilv_burst_tracker;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_sob = 1'b0;
    logic         in_eob = 1'b0;
    logic         in_sop = 1'b0;
    logic [2:0]   in_nvalid = '0;
    logic [3:0]   in_eop = '0;
    logic [7:0]   in_chan = '0;
    logic [255:0] in_data = '0;
    logic         beat_valid;
    logic [7:0]   beat_chan;
    logic [2:0]   beat_nvalid;
    logic [255:0] beat_data;
    logic         done_valid;
    logic [7:0]   done_chan;
    logic [15:0]  done_len;
    logic         err_sop_dup, err_orphan, err_stray, err_reopen;

    int checks = 0;
    int fails  = 0;
    int seq    = 0;

    bit ref_pkt [256];
    int ref_cnt [256];
    bit ref_open;
    int ref_chan;

    always #(CLK_PERIOD/2) clk = ~clk;

    ilv_burst_tracker dut (
        .clk(clk), .rst(rst), .in_sob(in_sob), .in_eob(in_eob), .in_sop(in_sop),
        .in_nvalid(in_nvalid), .in_eop(in_eop), .in_chan(in_chan), .in_data(in_data),
        .beat_valid(beat_valid), .beat_chan(beat_chan), .beat_nvalid(beat_nvalid),
        .beat_data(beat_data), .done_valid(done_valid), .done_chan(done_chan),
        .done_len(done_len), .err_sop_dup(err_sop_dup), .err_orphan(err_orphan),
        .err_stray(err_stray), .err_reopen(err_reopen)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 256; i++) begin
            ref_pkt[i] = 1'b0;
            ref_cnt[i] = 0;
        end
        ref_open = 1'b0;
        ref_chan = 0;
    endtask

    // Drive one beat at a falling edge, predict, and compare one cycle later.
    task automatic do_beat(input bit sob, input bit eob, input bit sop, input int nv,
                           input int eop, input int ch, input string tag);
        bit e_bv = 0, e_dv = 0, e_dup = 0, e_orph = 0, e_stray = 0, e_reop = 0;
        int e_ch = 0, e_len = 0, nvc, bytes, lb;
        logic [255:0] e_data;
        seq++;
        e_data = {8{32'(seq * 32'h9e3779b1)}};
        in_sob = sob; in_eob = eob; in_sop = sop; in_nvalid = 3'(nv);
        in_eop = 4'(eop); in_chan = 8'(ch); in_data = e_data;
        if (nv != 0) begin
            if (sob) begin
                e_reop = ref_open;
                e_ch = ch; ref_chan = ch; e_bv = 1;
                if (sop) begin
                    e_dup = ref_pkt[ch];
                    ref_cnt[ch] = 0;
                end else begin
                    e_orph = !ref_pkt[ch];
                end
            end else if (!ref_open) begin
                e_stray = 1;
            end else begin
                e_ch = ref_chan; e_bv = 1;
            end
            if (e_bv) begin
                nvc = (nv > 4) ? 4 : nv;
                lb  = eop & 7;
                bytes = ((eop & 8) != 0) ? (nvc - 1) * 8 + ((lb == 0) ? 8 : lb) : nvc * 8;
                ref_open = !eob;
                if ((eop & 8) != 0) begin
                    e_dv = 1; e_len = ref_cnt[e_ch] + bytes;
                    ref_pkt[e_ch] = 0; ref_cnt[e_ch] = 0;
                end else begin
                    ref_pkt[e_ch] = 1; ref_cnt[e_ch] += bytes;
                end
            end
        end
        @(posedge clk);
        @(negedge clk);
        chk(beat_valid == e_bv, tag, "beat_valid", beat_valid, e_bv);
        chk(done_valid == e_dv, tag, "done_valid", done_valid, e_dv);
        chk(err_sop_dup == e_dup, tag, "err_sop_dup", err_sop_dup, e_dup);
        chk(err_orphan == e_orph, tag, "err_orphan", err_orphan, e_orph);
        chk(err_stray == e_stray, tag, "err_stray", err_stray, e_stray);
        chk(err_reopen == e_reop, tag, "err_reopen", err_reopen, e_reop);
        if (e_bv) begin
            chk(beat_chan == 8'(e_ch), tag, "beat_chan", beat_chan, e_ch);
            chk(beat_nvalid == 3'(nv), tag, "beat_nvalid", beat_nvalid, nv);
            chk(beat_data == e_data, tag, "beat_data", beat_data[63:0], e_data[63:0]);
        end
        if (e_dv) begin
            chk(done_chan == 8'(e_ch), tag, "done_chan", done_chan, e_ch);
            chk(done_len == 16'(e_len), tag, "done_len", done_len, e_len);
        end
    endtask

    task automatic check_quiet(input string tag);
        chk(!beat_valid && !done_valid, tag, "outputs after reset",
            {beat_valid, done_valid}, 0);
        chk(!err_sop_dup && !err_orphan && !err_stray && !err_reopen, tag,
            "errors after reset", {err_sop_dup, err_orphan, err_stray, err_reopen}, 0);
    endtask

    task automatic do_reset();
        in_sob = 0; in_eob = 0; in_sop = 0; in_nvalid = '0; in_eop = '0;
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_clear();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check_quiet("R12");

        // R5/R6: every word count against every final-byte code, one-beat packets.
        for (int nv = 1; nv < 8; nv++) begin
            for (int lb = 0; lb < 8; lb++) begin
                do_beat(1, 1, 1, nv, 8 | lb, nv * 8 + lb, "R5");
            end
        end

        // R4/R5: one packet built from many one-beat bursts of every count.
        do_beat(1, 1, 1, 1, 0, 200, "R4");
        for (int nv = 1; nv < 8; nv++) begin
            do_beat(1, 1, 0, nv, 0, 200, "R5");
        end
        do_beat(1, 1, 0, 4, 8, 200, "R6");

        // R1/R2/R3/R4: three channels interleaved, garbage channel mid-burst, idles.
        do_beat(1, 0, 1, 4, 0, 2, "R1");
        do_beat(0, 1, 0, 4, 0, 8'hAA, "R2");
        do_beat(1, 1, 1, 2, 0, 4, "R4");
        do_beat(1, 1, 1, 0, 8, 9, "R3");
        do_beat(1, 0, 1, 4, 0, 9, "R4");
        do_beat(0, 0, 0, 0, 8, 8'h33, "R3");
        do_beat(0, 0, 0, 4, 0, 8'h02, "R2");
        do_beat(0, 1, 0, 1, 0, 8'h04, "R2");
        do_beat(1, 1, 0, 4, 0, 2, "R4");
        do_beat(1, 1, 0, 3, 4'b1011, 4, "R6");
        do_beat(1, 0, 0, 2, 0, 2, "R4");
        do_beat(0, 1, 0, 1, 4'b1101, 8'h55, "R6");
        do_beat(1, 1, 0, 1, 4'b1000, 9, "R6");

        // R11: start-of-packet inside a burst is ignored.
        do_beat(1, 0, 1, 4, 0, 7, "R11");
        do_beat(0, 0, 1, 4, 0, 7, "R11");
        do_beat(0, 1, 0, 2, 4'b1010, 7, "R11");

        // R7: duplicate start of packet coinciding with a completion.
        do_beat(1, 1, 1, 4, 0, 3, "R7");
        do_beat(1, 1, 1, 2, 4'b1001, 3, "R7");

        // R8: continuation on an idle channel opens a packet.
        do_beat(1, 1, 0, 2, 0, 5, "R8");
        do_beat(1, 1, 0, 1, 4'b1000, 5, "R8");

        // R9: beat outside any burst is dropped.
        do_beat(0, 1, 0, 3, 8, 5, "R9");
        do_beat(1, 1, 1, 1, 4'b1000, 5, "R9");

        // R10: new burst while one is open, with a completion in the same cycle.
        do_beat(1, 0, 1, 2, 0, 6, "R10");
        do_beat(1, 1, 1, 1, 4'b1000, 10, "R10");
        do_beat(1, 1, 0, 1, 4'b1100, 6, "R4");

        // R12: reset mid-packet forgets the channel state.
        do_beat(1, 0, 1, 4, 0, 11, "R12");
        do_reset();
        check_quiet("R12");
        do_beat(0, 1, 0, 2, 0, 11, "R12");
        do_beat(1, 1, 0, 1, 4'b1000, 11, "R12");

        in_sob = 0; in_eob = 0; in_sop = 0; in_nvalid = '0; in_eop = '0;
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule